// File: doc/BRIEF.md
# Transceiver operating mode controller

This block is the mode sequencer of a packet radio. It decides, clock by clock, whether the radio is held in power-on reset, switched off, idling in one of two standby levels, listening, or sending. Its inputs are two configuration bits (power-up and primary-receiver), the chip-enable line, and status from the queues and the modem: TX queue empty, RX queue full, a packet-finished strobe from the transmitter and a good-packet strobe from the receiver. From these it drives the current mode code, a pop request to the TX queue, a push-or-discard decision for each received packet, and enables for the oscillator and the PLL.

All timing is counted in clock ticks. A chip-enable pulse is only accepted for transmission once it has been high for more than `CE_HOLD_TICKS` ticks. A short qualified pulse sends one queued packet. Chip-enable held high drains the whole queue and then parks the radio in a warm standby, which restarts transmission the moment new data is queued. A dwell guard flags any single stay in transmit longer than `TX_LIMIT_TICKS` ticks. The receive path has no back-pressure. A good packet is either pushed into the RX queue in the same cycle or discarded when that queue is full. The modem never waits.

Top module: `radio_mode_ctrl`

## Requirements
- R1: Mode codes are 0 = power-on reset, 1 = off, 2 = idle standby, 3 = warm standby, 4 = receive, 5 = transmit. While `rst_n` is low the mode is 0. At the first clock edge after release it becomes 1 (off). In modes 0 and 1 every request and enable output is 0.
- R2: When `cfg_pwr_up` is 0 at a clock edge, the next mode is off, whatever the current mode. A packet in flight is abandoned without a TX pop. When `cfg_pwr_up` is 1 in off, the next mode is idle standby.
- R3: In idle standby with `cfg_prim_rx` = 1 and `ce` = 1, the next mode is receive. In receive, `ce` = 0 returns to idle standby at the next edge.
- R4: In receive, a `rx_pkt_valid` strobe raises `rxq_push` in the same cycle when `rxq_full` is 0, or raises `rx_drop` when it is 1. Outside receive the strobe raises neither.
- R5: Idle standby moves to transmit only when `cfg_prim_rx` = 0, `txq_empty` = 0 and `ce` has been sampled high on more than `CE_HOLD_TICKS` consecutive edges. Any low sample restarts the count. A shorter pulse leaves the mode unchanged.
- R6: `txq_pop` is raised for exactly the cycle in which `tx_pkt_done` ends a packet in transmit. A `tx_pkt_done` while no packet is in flight is ignored.
- R7: When a packet ends with `ce` = 0, the next mode is idle standby. A qualified pulse that falls before the first packet ends therefore sends one entry.
- R8: When a packet ends with `ce` = 1, the mode stays in transmit for one turnaround cycle. If `txq_empty` = 0 in that cycle the next packet starts. If `txq_empty` = 1 the next mode is warm standby.
- R9: In warm standby, `txq_empty` = 0 moves to transmit at the next edge with no new CE qualification. `ce` = 0 moves to idle standby.
- R10: `tx_dwell_viol` is 1 from the (`TX_LIMIT_TICKS`+1)-th consecutive transmit cycle on. It is 0 in every other mode.
- R11: `osc_en` is 1 in modes 2 to 5. `pll_en` is 1 only in receive and transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwr_up | input | 1 | Power-up configuration bit |
| cfg_prim_rx | input | 1 | 1 selects receiver role, 0 transmitter role |
| ce | input | 1 | Chip-enable line |
| txq_empty | input | 1 | TX queue holds no entry |
| rxq_full | input | 1 | RX queue has no free slot |
| tx_pkt_done | input | 1 | Transmitter finished the current packet |
| rx_pkt_valid | input | 1 | Receiver found a packet with matching address and good CRC |
| mode | output | 3 | Current mode code (R1) |
| txq_pop | output | 1 | Remove the head entry of the TX queue |
| rxq_push | output | 1 | Write the received packet into the RX queue |
| rx_drop | output | 1 | Received packet discarded, RX queue full |
| pll_en | output | 1 | Synthesizer enable |
| osc_en | output | 1 | Crystal oscillator enable |
| tx_dwell_viol | output | 1 | Transmit stretch exceeded its tick limit |

## Verification
The mode code is the state register itself, so a wrong transition is visible on `mode` at the very next edge. The stimulus walks each edge of the mode graph and compares the code after every clock. The hidden parts of the state appear more slowly. A CE count that is off by one moves the transmit entry by one edge, or lets a too-short pulse through. A lost in-flight flag shows up as a missing or doubled `txq_pop` on the next `tx_pkt_done`, or as a missing turnaround cycle before warm standby. A dwell counter that does not restart shows up after exactly `TX_LIMIT_TICKS`+1 transmit cycles as a flag raised too early or too late.

// File: rtl/radio_mode_pkg.sv
package radio_mode_pkg;
  typedef enum logic [2:0] {
    MODE_POR  = 3'd0,
    MODE_OFF  = 3'd1,
    MODE_IDLE = 3'd2,
    MODE_WARM = 3'd3,
    MODE_RX   = 3'd4,
    MODE_TX   = 3'd5
  } radio_mode_e;
endpackage

// File: rtl/ce_hold_timer.sv
// Counts consecutive high samples of chip-enable; qualifies once more than
// HOLD_TICKS samples have been seen and the line is still high.
module ce_hold_timer #(
  parameter int HOLD_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  output logic ce_qualified
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] SAT = CW'(HOLD_TICKS);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!ce) begin
      hold_cnt <= '0;
    end else if (hold_cnt != SAT) begin
      hold_cnt <= hold_cnt + CW'(1);
    end
  end

  assign ce_qualified = ce && (hold_cnt == SAT);
endmodule

// File: rtl/tx_dwell_guard.sv
// Measures one uninterrupted transmit stretch and flags it past the limit.
module tx_dwell_guard #(
  parameter int LIMIT_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tx,
  output logic over_limit
);
  localparam int DW = $clog2(LIMIT_TICKS + 1);
  localparam logic [DW-1:0] LIM = DW'(LIMIT_TICKS);

  logic [DW-1:0] dwell_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_cnt <= '0;
    end else if (!in_tx) begin
      dwell_cnt <= '0;
    end else if (dwell_cnt != LIM) begin
      dwell_cnt <= dwell_cnt + DW'(1);
    end
  end

  assign over_limit = in_tx && (dwell_cnt == LIM);
endmodule

// File: rtl/rx_admit.sv
// Per-packet admission: push into a free RX slot, otherwise discard.
module rx_admit (
  input  logic in_rx,
  input  logic pkt_valid,
  input  logic q_full,
  output logic push,
  output logic drop
);
  always_comb begin
    push = in_rx && pkt_valid && !q_full;
    drop = in_rx && pkt_valid && q_full;
  end
endmodule

// File: rtl/mode_fsm.sv
// Mode sequencer. pkt_active marks a packet in flight while in transmit;
// with it clear, transmit is in its turnaround cycle.
module mode_fsm
  import radio_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_up,
  input  logic        prim_rx,
  input  logic        ce,
  input  logic        ce_qualified,
  input  logic        txq_empty,
  input  logic        pkt_done,
  output radio_mode_e state,
  output logic        pop
);
  radio_mode_e state_n;
  logic        active_q, active_n;

  always_comb begin
    state_n  = state;
    active_n = active_q;
    pop      = 1'b0;
    if (!pwr_up) begin
      state_n  = MODE_OFF;
      active_n = 1'b0;
    end else begin
      unique case (state)
        MODE_POR:  state_n = MODE_OFF;
        MODE_OFF:  state_n = MODE_IDLE;
        MODE_IDLE: begin
          if (ce && prim_rx) begin
            state_n = MODE_RX;
          end else if (!prim_rx && !txq_empty && ce_qualified) begin
            state_n  = MODE_TX;
            active_n = 1'b1;
          end
        end
        MODE_WARM: begin
          if (!ce) begin
            state_n = MODE_IDLE;
          end else if (!txq_empty) begin
            state_n  = MODE_TX;
            active_n = 1'b1;
          end
        end
        MODE_RX: begin
          if (!ce) state_n = MODE_IDLE;
        end
        MODE_TX: begin
          if (active_q) begin
            if (pkt_done) begin
              pop      = 1'b1;
              active_n = 1'b0;
              if (!ce) state_n = MODE_IDLE;
            end
          end else begin
            if (!ce) begin
              state_n = MODE_IDLE;
            end else if (txq_empty) begin
              state_n = MODE_WARM;
            end else begin
              active_n = 1'b1;
            end
          end
        end
        default: begin
          state_n  = MODE_OFF;
          active_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MODE_POR;
      active_q <= 1'b0;
    end else begin
      state    <= state_n;
      active_q <= active_n;
    end
  end
endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import radio_mode_pkg::*;
#(
  parameter int CE_HOLD_TICKS  = 10,
  parameter int TX_LIMIT_TICKS = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pwr_up,
  input  logic       cfg_prim_rx,
  input  logic       ce,
  input  logic       txq_empty,
  input  logic       rxq_full,
  input  logic       tx_pkt_done,
  input  logic       rx_pkt_valid,
  output logic [2:0] mode,
  output logic       txq_pop,
  output logic       rxq_push,
  output logic       rx_drop,
  output logic       pll_en,
  output logic       osc_en,
  output logic       tx_dwell_viol
);
  radio_mode_e state;
  logic        ce_ok;

  ce_hold_timer #(.HOLD_TICKS(CE_HOLD_TICKS)) u_ce_timer (
    .clk(clk), .rst_n(rst_n), .ce(ce), .ce_qualified(ce_ok)
  );

  mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_up(cfg_pwr_up), .prim_rx(cfg_prim_rx),
    .ce(ce), .ce_qualified(ce_ok), .txq_empty(txq_empty),
    .pkt_done(tx_pkt_done), .state(state), .pop(txq_pop)
  );

  tx_dwell_guard #(.LIMIT_TICKS(TX_LIMIT_TICKS)) u_dwell (
    .clk(clk), .rst_n(rst_n), .in_tx(state == MODE_TX),
    .over_limit(tx_dwell_viol)
  );

  rx_admit u_rx_admit (
    .in_rx(state == MODE_RX), .pkt_valid(rx_pkt_valid), .q_full(rxq_full),
    .push(rxq_push), .drop(rx_drop)
  );

  always_comb begin
    mode   = state;
    pll_en = (state == MODE_RX) || (state == MODE_TX);
    osc_en = (state == MODE_IDLE) || (state == MODE_WARM) || pll_en;
  end
endmodule

// File: rtl/radio_mode_ctrl_chk.sv
module radio_mode_ctrl_chk
  import radio_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pwr_up,
  input logic       cfg_prim_rx,
  input logic       ce,
  input logic       txq_empty,
  input logic       rxq_full,
  input logic       rx_pkt_valid,
  input logic [2:0] mode,
  input logic       txq_pop,
  input logic       rxq_push,
  input logic       rx_drop,
  input logic       pll_en,
  input logic       osc_en,
  input logic       tx_dwell_viol
);
  // R1
  por_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_POR) |=> (mode == MODE_OFF));

  // R2
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pwr_up |=> (mode == MODE_OFF));

  // R3
  rx_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RX && cfg_pwr_up && !ce) |=> (mode == MODE_IDLE));

  // R4
  rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> (mode == MODE_RX && rx_pkt_valid && !rxq_full && !rx_drop));

  // R4
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> (mode == MODE_RX && rx_pkt_valid && rxq_full));

  // R5
  tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE && (!ce || cfg_prim_rx || txq_empty)) |=> (mode != MODE_TX));

  // R6
  pop_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (mode == MODE_TX && cfg_pwr_up));

  // R9
  warm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WARM && cfg_pwr_up && !ce) |=> (mode == MODE_IDLE));

  // R10
  dwell_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dwell_viol |-> (mode == MODE_TX));

  // R11
  pll_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en);
endmodule

bind radio_mode_ctrl radio_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pwr_up(cfg_pwr_up), .cfg_prim_rx(cfg_prim_rx),
  .ce(ce), .txq_empty(txq_empty), .rxq_full(rxq_full),
  .rx_pkt_valid(rx_pkt_valid), .mode(mode), .txq_pop(txq_pop),
  .rxq_push(rxq_push), .rx_drop(rx_drop), .pll_en(pll_en), .osc_en(osc_en),
  .tx_dwell_viol(tx_dwell_viol)
);

// File: tb/radio_mode_ctrl_tb.sv
`timescale 1ns/1ps
module radio_mode_ctrl_tb;
  localparam int HOLD  = 3;
  localparam int LIMIT = 20;
  localparam int NV    = 36;

  // {pwr,prim,ce,empty,rxfull,done,valid, mode_after[2:0], pop,push,drop}
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_0_1_0_0_0_001_000, // 0  R2 off holds
    13'b1_1_0_1_0_0_0_010_000, // 1  R2 off->idle
    13'b1_1_1_1_0_0_0_100_000, // 2  R3 enter rx
    13'b1_1_1_1_0_0_1_100_010, // 3  R4 push
    13'b1_1_1_1_1_0_1_100_001, // 4  R4 drop
    13'b1_1_0_1_0_0_0_010_000, // 5  R3 rx->idle
    13'b1_0_1_0_0_0_0_010_000, // 6  R5 count 1
    13'b1_0_1_0_0_0_0_010_000, // 7
    13'b1_0_1_0_0_0_0_010_000, // 8
    13'b1_0_0_0_0_0_0_010_000, // 9  R5 short pulse ignored
    13'b1_0_1_0_0_0_0_010_000, // 10
    13'b1_0_1_0_0_0_0_010_000, // 11
    13'b1_0_1_0_0_0_0_010_000, // 12
    13'b1_0_1_0_0_0_0_101_000, // 13 R5 qualified -> tx
    13'b1_0_0_0_0_0_0_101_000, // 14 R7 pulse fell, still sending
    13'b1_0_0_0_0_1_0_010_100, // 15 R7 one entry sent
    13'b1_0_1_0_0_0_0_010_000, // 16
    13'b1_0_1_0_0_0_0_010_000, // 17
    13'b1_0_1_0_0_0_0_010_000, // 18
    13'b1_0_1_0_0_0_0_101_000, // 19 R5
    13'b1_0_1_0_0_1_0_101_100, // 20 R8 done, turnaround
    13'b1_0_1_0_0_1_0_101_000, // 21 R6 stray done ignored
    13'b1_0_1_0_0_1_0_101_100, // 22 R8
    13'b1_0_1_1_0_0_0_011_000, // 23 R8 empty -> warm
    13'b1_0_1_1_0_0_0_011_000, // 24 R9 waits
    13'b1_0_1_0_0_0_0_101_000, // 25 R9 data -> tx
    13'b0_0_1_0_0_1_0_001_000, // 26 R2 abort no pop
    13'b1_0_0_1_0_0_0_010_000, // 27 R2
    13'b1_0_1_0_0_0_0_010_000, // 28
    13'b1_0_1_0_0_0_0_010_000, // 29
    13'b1_0_1_0_0_0_0_010_000, // 30
    13'b1_0_1_0_0_0_0_101_000, // 31 R5
    13'b1_0_1_0_0_1_0_101_100, // 32 R6
    13'b1_0_1_1_0_0_0_011_000, // 33 R8
    13'b1_0_0_1_0_0_0_010_000, // 34 R9 ce low -> idle
    13'b1_0_0_1_0_0_1_010_000  // 35 R4 valid outside rx ignored
  };
  localparam int VREQ [NV] = '{2,2,3,4,4,3,5,5,5,5,5,5,5,5,7,7,5,5,5,5,
                               8,6,8,8,9,9,2,2,5,5,5,5,6,8,9,4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pwr_up = 1'b0, cfg_prim_rx = 1'b0, ce = 1'b0;
  logic txq_empty = 1'b1, rxq_full = 1'b0, tx_pkt_done = 1'b0, rx_pkt_valid = 1'b0;
  logic [2:0] mode;
  logic txq_pop, rxq_push, rx_drop, pll_en, osc_en, tx_dwell_viol;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  radio_mode_ctrl #(.CE_HOLD_TICKS(HOLD), .TX_LIMIT_TICKS(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pwr_up(cfg_pwr_up), .cfg_prim_rx(cfg_prim_rx),
    .ce(ce), .txq_empty(txq_empty), .rxq_full(rxq_full),
    .tx_pkt_done(tx_pkt_done), .rx_pkt_valid(rx_pkt_valid), .mode(mode),
    .txq_pop(txq_pop), .rxq_push(rxq_push), .rx_drop(rx_drop),
    .pll_en(pll_en), .osc_en(osc_en), .tx_dwell_viol(tx_dwell_viol)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk("R1", "mode in reset", int'(mode), 0);
    chk("R1", "osc in reset", int'(osc_en), 0);
    chk("R1", "pll in reset", int'(pll_en), 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "mode after por", int'(mode), 1);
    chk("R1", "osc off", int'(osc_en), 0);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row%0d", VREQ[i], i);
      cfg_pwr_up   = v[12];
      cfg_prim_rx  = v[11];
      ce           = v[10];
      txq_empty    = v[9];
      rxq_full     = v[8];
      tx_pkt_done  = v[7];
      rx_pkt_valid = v[6];
      #1;
      chk(tag, "txq_pop", int'(txq_pop), int'(v[2]));
      chk(tag, "rxq_push", int'(rxq_push), int'(v[1]));
      chk(tag, "rx_drop", int'(rx_drop), int'(v[0]));
      tick();
      chk(tag, "mode", int'(mode), int'(v[5:3]));
    end
    tx_pkt_done = 1'b0;
    rx_pkt_valid = 1'b0;

    // R11: enables in idle and receive
    chk("R11", "osc idle", int'(osc_en), 1);
    chk("R11", "pll idle", int'(pll_en), 0);
    cfg_prim_rx = 1'b1; ce = 1'b1;
    tick();
    chk("R3", "mode rx", int'(mode), 4);
    chk("R11", "pll rx", int'(pll_en), 1);

    // R10: dwell limit
    cfg_prim_rx = 1'b0; txq_empty = 1'b0; ce = 1'b0;
    tick();
    chk("R3", "rx to idle", int'(mode), 2);
    ce = 1'b1;
    repeat (HOLD + 1) tick();
    chk("R5", "tx entered", int'(mode), 5);
    chk("R11", "pll tx", int'(pll_en), 1);
    chk("R10", "viol first tx cycle", int'(tx_dwell_viol), 0);
    repeat (LIMIT - 1) tick();
    chk("R10", "viol at limit", int'(tx_dwell_viol), 0);
    tick();
    chk("R10", "viol past limit", int'(tx_dwell_viol), 1);
    ce = 1'b0; tx_pkt_done = 1'b1;
    #1;
    chk("R6", "pop at end", int'(txq_pop), 1);
    tick();
    tx_pkt_done = 1'b0;
    chk("R7", "idle after end", int'(mode), 2);
    chk("R10", "viol cleared", int'(tx_dwell_viol), 0);

    // R1: reset during receive
    cfg_prim_rx = 1'b1; ce = 1'b1;
    tick();
    chk("R3", "rx again", int'(mode), 4);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset", int'(mode), 0);
    chk("R1", "pll in reset", int'(pll_en), 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "off after reset", int'(mode), 1);
    tick();
    chk("R2", "idle after off", int'(mode), 2);

    summary();
  end
endmodule